// File: doc/BRIEF.md
# Serial PSRAM Identification Probe

This controller runs once after reset. It checks which serial pseudo-static RAM is attached before any other traffic reaches it. It does not shift bits itself. Each byte goes to a byte-exchange engine through a valid/ready transmit channel. The matching received byte comes back on a valid/ready receive channel. A plain `eng_busy` level shows when the engine still has work in progress.

The probe opens the engine and sends a reset-enable command over four data lanes inside its own chip-select window. It throws away whatever byte comes back. It then releases chip select and opens a second window on a single lane. In that window it exchanges seven bytes: the read-identification opcode and then six filler bytes. Two of the returned bytes are kept: the die-quality byte and the extended identifier byte. The probe decodes a capacity from them and compares it with the `EXPECTED_BYTES` parameter.

When the probe finishes, it closes the engine and raises `done` for one cycle. It then holds the decoded size and a status bit until the next reset.

Back-pressure rules:
- Once `tx_valid` rises, it stays high with `tx_data` and `tx_quad` unchanged until a cycle with `tx_ready` high.
- `rx_ready` is high only while the probe is waiting for the response to the byte it just handed over.
- The engine must keep exactly one response per accepted byte.

Top module: `psprobe_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `xfer_en`, `cs_assert`, `tx_valid`, `rx_ready` and `done` are low, and `det_size` and `status` are zero.
- R2: The first byte handed to the engine is 0xF5 with `tx_quad` = 1. It is alone inside the first chip-select window, and its response is accepted and discarded.
- R3: Chip select drops between the two windows. The second window carries exactly seven bytes with `tx_quad` = 0: 0x9F in slot 0, then 0xFF in slots 1 to 6.
- R4: `tx_valid` stays high with `tx_data` and `tx_quad` stable until `tx_ready` is seen. `tx_valid` only occurs with `xfer_en` and `cs_assert` high, and each accepted byte has exactly one response taken.
- R5: Chip select is not first raised while `eng_busy` is high. No byte is offered while `eng_busy` is high, so the probe waits for idle after every response before moving on.
- R6: The response in slot 5 of the second window is the die-quality byte and the response in slot 6 is the extended identifier. Responses in every other slot, and in the first window, have no effect on the result.
- R7: If the die-quality byte is not 0x5D, the detected size is 0.
- R8: With a good die byte, the size depends on the extended identifier:
  - 8 MiB if the identifier is 0x26 or its bits [7:5] equal 2.
  - Otherwise 2 MiB if bits [7:5] equal 0, and 4 MiB if they equal 1.
  - 1 MiB for any other value.
- R9: `status` is 1 (size mismatch) when the detected size differs from `EXPECTED_BYTES`, and 0 (ok) when it matches.
- R10: `done` rises exactly once per reset, for one cycle, with `xfer_en` and `cs_assert` low. `det_size` and `status` are valid in that cycle and held afterwards, with no further engine traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the probe restarts on release |
| xfer_en | output | 1 | Enables the byte-exchange engine |
| cs_assert | output | 1 | Chip-select request, high = selected |
| tx_valid | output | 1 | Byte offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered byte |
| tx_data | output | 8 | Byte to shift out |
| tx_quad | output | 1 | 1 = four lanes, 0 = single lane |
| rx_valid | input | 1 | Response byte available |
| rx_ready | output | 1 | Probe takes the response byte |
| rx_data | input | 8 | Response byte |
| eng_busy | input | 1 | Engine still shifting |
| done | output | 1 | One-cycle completion pulse |
| det_size | output | SIZE_W | Decoded capacity in bytes |
| status | output | 1 | 0 = ok, 1 = size mismatch |

## Verification
The assertions assume the engine behaves as follows:
- It raises `eng_busy` or `rx_valid` only in response to an accepted byte, apart from a busy period just after reset.
- It never drops `tx_ready` in a way that matters to the hold rule.
- It presents exactly one response per byte.

The bench engine model respects these assumptions and randomises the rest:
- random `tx_ready` gaps
- random shifting latency
- random busy tails after each response, during which `tx_ready` may already be high
- a random busy period after reset

Die-quality and identifier bytes are drawn at random and mixed with directed boundary codes. Filler responses in unused slots are random, so any leak from those slots into the result would show up as a wrong size.

// File: rtl/psprobe_pkg.sv
`timescale 1ns/1ps
package psprobe_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_RESET_EN = 8'hF5;
  localparam logic [BYTE_W-1:0] OP_READ_ID  = 8'h9F;
  localparam logic [BYTE_W-1:0] OP_FILL     = 8'hFF;
  localparam logic [BYTE_W-1:0] DIE_GOOD    = 8'h5D;
  localparam logic [BYTE_W-1:0] EID_ALIAS8  = 8'h26;

  typedef enum logic [3:0] {
    PS_OPEN,
    PS_ARM,
    PS_R_SEL,
    PS_R_SEND,
    PS_R_RECV,
    PS_R_SETTLE,
    PS_R_DROP,
    PS_I_SEL,
    PS_I_SEND,
    PS_I_RECV,
    PS_I_SETTLE,
    PS_CLOSE,
    PS_REPORT,
    PS_HALT
  } probe_state_e;

  typedef enum logic [2:0] {
    CAP_NONE,
    CAP_1X,
    CAP_2X,
    CAP_4X,
    CAP_8X
  } cap_code_e;

  typedef enum logic {
    PROBE_OK       = 1'b0,
    PROBE_SIZE_ERR = 1'b1
  } probe_status_e;

endpackage

// File: rtl/psprobe_script.sv
`timescale 1ns/1ps
module psprobe_script
  import psprobe_pkg::*;
#(
  parameter int unsigned ID_SLOTS = 7,
  localparam int unsigned SLOT_W  = (ID_SLOTS > 1) ? $clog2(ID_SLOTS) : 1,
  localparam int unsigned TBL_N   = 1 << SLOT_W
) (
  input  logic              id_phase,
  input  logic [SLOT_W-1:0] slot,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_quad
);

  logic [BYTE_W-1:0] slot_tbl [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_slot
    if (g == 0) begin : g_opcode
      assign slot_tbl[g] = OP_READ_ID;
    end else begin : g_filler
      assign slot_tbl[g] = OP_FILL;
    end
  end

  always_comb begin
    if (id_phase) begin
      cmd_byte = slot_tbl[slot];
      cmd_quad = 1'b0;
    end else begin
      cmd_byte = OP_RESET_EN;
      cmd_quad = 1'b1;
    end
  end

endmodule

// File: rtl/psprobe_capture.sv
`timescale 1ns/1ps
module psprobe_capture
  import psprobe_pkg::*;
#(
  parameter int unsigned SLOT_W   = 3,
  parameter int unsigned DIE_SLOT = 5,
  parameter int unsigned EID_SLOT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] die_byte,
  output logic [BYTE_W-1:0] eid_byte
);

  localparam int unsigned N_PICK = 2;
  localparam int unsigned PICK_AT [N_PICK] = '{DIE_SLOT, EID_SLOT};

  logic [BYTE_W-1:0] held [N_PICK];

  for (genvar g = 0; g < N_PICK; g++) begin : g_pick
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[g] <= '0;
      end else if (strobe && (slot == SLOT_W'(PICK_AT[g]))) begin
        held[g] <= rx_byte;
      end
    end
  end

  assign die_byte = held[0];
  assign eid_byte = held[1];

endmodule

// File: rtl/psprobe_decode.sv
`timescale 1ns/1ps
module psprobe_decode
  import psprobe_pkg::*;
#(
  parameter int unsigned SIZE_W         = 32,
  parameter int unsigned UNIT_BYTES     = 1048576,
  parameter int unsigned EXPECTED_BYTES = 8388608
) (
  input  logic [BYTE_W-1:0] die_byte,
  input  logic [BYTE_W-1:0] eid_byte,
  output logic [SIZE_W-1:0] size_bytes,
  output logic              mismatch
);

  localparam logic [SIZE_W-1:0] UNIT = SIZE_W'(UNIT_BYTES);
  localparam logic [SIZE_W-1:0] WANT = SIZE_W'(EXPECTED_BYTES);

  cap_code_e  cap;
  logic [2:0] density;

  assign density = eid_byte[7:5];

  always_comb begin
    cap = CAP_NONE;
    if (die_byte == DIE_GOOD) begin
      if ((eid_byte == EID_ALIAS8) || (density == 3'd2)) begin
        cap = CAP_8X;
      end else if (density == 3'd0) begin
        cap = CAP_2X;
      end else if (density == 3'd1) begin
        cap = CAP_4X;
      end else begin
        cap = CAP_1X;
      end
    end
  end

  always_comb begin
    unique case (cap)
      CAP_1X:  size_bytes = UNIT;
      CAP_2X:  size_bytes = UNIT << 1;
      CAP_4X:  size_bytes = UNIT << 2;
      CAP_8X:  size_bytes = UNIT << 3;
      default: size_bytes = '0;
    endcase
  end

  assign mismatch = (size_bytes != WANT);

endmodule

// File: rtl/psprobe_top.sv
`timescale 1ns/1ps
module psprobe_top
  import psprobe_pkg::*;
#(
  parameter int unsigned SIZE_W         = 32,
  parameter int unsigned EXPECTED_BYTES = 8388608,
  parameter int unsigned UNIT_BYTES     = 1048576,
  parameter int unsigned ID_SLOTS       = 7,
  parameter int unsigned DIE_SLOT       = 5,
  parameter int unsigned EID_SLOT       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              xfer_en,
  output logic              cs_assert,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_quad,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              eng_busy,
  output logic              done,
  output logic [SIZE_W-1:0] det_size,
  output logic              status
);

  localparam int unsigned SLOT_W = (ID_SLOTS > 1) ? $clog2(ID_SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(ID_SLOTS - 1);

  probe_state_e      st_q, st_d;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_clr, slot_inc, grab, latch;
  logic              id_phase;
  logic [BYTE_W-1:0] die_byte, eid_byte;
  logic [SIZE_W-1:0] size_now, size_q;
  logic              mism_now;
  probe_status_e     status_q;

  // command byte source: four-lane reset-enable or slot-indexed ID script
  psprobe_script #(.ID_SLOTS(ID_SLOTS)) u_script (
    .id_phase (id_phase),
    .slot     (slot_q),
    .cmd_byte (tx_data),
    .cmd_quad (tx_quad)
  );

  psprobe_capture #(
    .SLOT_W   (SLOT_W),
    .DIE_SLOT (DIE_SLOT),
    .EID_SLOT (EID_SLOT)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (grab),
    .slot     (slot_q),
    .rx_byte  (rx_data),
    .die_byte (die_byte),
    .eid_byte (eid_byte)
  );

  psprobe_decode #(
    .SIZE_W         (SIZE_W),
    .UNIT_BYTES     (UNIT_BYTES),
    .EXPECTED_BYTES (EXPECTED_BYTES)
  ) u_decode (
    .die_byte   (die_byte),
    .eid_byte   (eid_byte),
    .size_bytes (size_now),
    .mismatch   (mism_now)
  );

  // sequencing
  always_comb begin
    st_d     = st_q;
    slot_clr = 1'b0;
    slot_inc = 1'b0;
    grab     = 1'b0;
    latch    = 1'b0;
    unique case (st_q)
      PS_OPEN:     st_d = PS_ARM;
      PS_ARM:      if (!eng_busy) st_d = PS_R_SEL;
      PS_R_SEL:    st_d = PS_R_SEND;
      PS_R_SEND:   if (tx_ready) st_d = PS_R_RECV;
      PS_R_RECV:   if (rx_valid) st_d = PS_R_SETTLE;
      PS_R_SETTLE: if (!eng_busy) st_d = PS_R_DROP;
      PS_R_DROP:   st_d = PS_I_SEL;
      PS_I_SEL: begin
        slot_clr = 1'b1;
        st_d     = PS_I_SEND;
      end
      PS_I_SEND:   if (tx_ready) st_d = PS_I_RECV;
      PS_I_RECV: begin
        if (rx_valid) begin
          grab = 1'b1;
          st_d = PS_I_SETTLE;
        end
      end
      PS_I_SETTLE: begin
        if (!eng_busy) begin
          if (slot_q == LAST_SLOT) begin
            st_d = PS_CLOSE;
          end else begin
            slot_inc = 1'b1;
            st_d     = PS_I_SEND;
          end
        end
      end
      PS_CLOSE: begin
        latch = 1'b1;
        st_d  = PS_REPORT;
      end
      PS_REPORT:   st_d = PS_HALT;
      default:     st_d = PS_HALT;
    endcase
  end

  // pin levels per state
  always_comb begin
    xfer_en   = 1'b0;
    cs_assert = 1'b0;
    tx_valid  = 1'b0;
    rx_ready  = 1'b0;
    done      = 1'b0;
    id_phase  = 1'b0;
    unique case (st_q)
      PS_ARM, PS_R_DROP: xfer_en = 1'b1;
      PS_R_SEL, PS_R_SETTLE: begin
        xfer_en   = 1'b1;
        cs_assert = 1'b1;
      end
      PS_R_SEND: begin
        xfer_en   = 1'b1;
        cs_assert = 1'b1;
        tx_valid  = 1'b1;
      end
      PS_R_RECV: begin
        xfer_en   = 1'b1;
        cs_assert = 1'b1;
        rx_ready  = 1'b1;
      end
      PS_I_SEL, PS_I_SETTLE: begin
        xfer_en   = 1'b1;
        cs_assert = 1'b1;
        id_phase  = 1'b1;
      end
      PS_I_SEND: begin
        xfer_en   = 1'b1;
        cs_assert = 1'b1;
        tx_valid  = 1'b1;
        id_phase  = 1'b1;
      end
      PS_I_RECV: begin
        xfer_en   = 1'b1;
        cs_assert = 1'b1;
        rx_ready  = 1'b1;
        id_phase  = 1'b1;
      end
      PS_REPORT: done = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= PS_OPEN;
      slot_q   <= '0;
      size_q   <= '0;
      status_q <= PROBE_OK;
    end else begin
      st_q <= st_d;
      if (slot_clr) begin
        slot_q <= '0;
      end else if (slot_inc) begin
        slot_q <= slot_q + 1'b1;
      end
      if (latch) begin
        size_q   <= size_now;
        status_q <= mism_now ? PROBE_SIZE_ERR : PROBE_OK;
      end
    end
  end

  assign det_size = size_q;
  assign status   = status_q;

endmodule

// File: rtl/psprobe_checker.sv
`timescale 1ns/1ps
module psprobe_checker #(
  parameter int unsigned SIZE_W         = 32,
  parameter int unsigned EXPECTED_BYTES = 8388608
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_en,
  input logic              cs_assert,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_quad,
  input logic              rx_ready,
  input logic              eng_busy,
  input logic              done,
  input logic [SIZE_W-1:0] det_size,
  input logic              status
);

  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_quad));

  a_r4_tx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> cs_assert && xfer_en);

  a_r4_rx_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> cs_assert && !tx_valid);

  a_r2_quad_only_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_quad |-> tx_data == 8'hF5);

  a_r3_single_script: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_quad |-> (tx_data == 8'h9F) || (tx_data == 8'hFF));

  a_r5_idle_offer: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !eng_busy);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_closed: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cs_assert && !xfer_en);

  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(det_size) && $stable(status));

  a_r9_status_rule: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status == (det_size != SIZE_W'(EXPECTED_BYTES)));

endmodule

bind psprobe_top psprobe_checker #(
  .SIZE_W         (SIZE_W),
  .EXPECTED_BYTES (EXPECTED_BYTES)
) u_psprobe_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_en   (xfer_en),
  .cs_assert (cs_assert),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_quad   (tx_quad),
  .rx_ready  (rx_ready),
  .eng_busy  (eng_busy),
  .done      (done),
  .det_size  (det_size),
  .status    (status)
);

// File: tb/psprobe_top_bench.sv
`timescale 1ns/1ps
module psprobe_top_bench;

  localparam int unsigned SZW  = 32;
  localparam int unsigned WANT = 8388608;
  localparam int unsigned MIB  = 1048576;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_en, cs_assert, tx_valid, tx_quad, rx_ready, done, status;
  logic [7:0] tx_data;
  logic       tx_ready, rx_valid, eng_busy;
  logic [7:0] rx_data;
  logic [SZW-1:0] det_size;

  always #5 clk = ~clk;

  psprobe_top u_psprobe_top (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .cs_assert(cs_assert),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_quad(tx_quad),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_busy(eng_busy), .done(done), .det_size(det_size), .status(status)
  );

  int checks = 0;
  int fails  = 0;

  // scenario settings
  logic [7:0] die_v, eid_v;
  int         boot_v;

  // engine model state
  int         boot_cnt, lat_cnt, tail_cnt, sess, slot, log_n, rx_acc, done_n, viol, early_cs;
  logic       in_flight, cs_q;
  logic [7:0] resp;
  logic [7:0] log_data [16];
  logic       log_quad [16];
  int         log_sess [16];
  logic [SZW-1:0] cap_size;
  logic       cap_stat, cap_open;

  assign eng_busy = (boot_cnt != 0) || (in_flight && !rx_valid) || (tail_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      boot_cnt <= boot_v; lat_cnt <= 0; tail_cnt <= 0; sess <= 0; slot <= 0;
      log_n <= 0; rx_acc <= 0; done_n <= 0; viol <= 0; early_cs <= 0;
      in_flight <= 1'b0; cs_q <= 1'b0; tx_ready <= 1'b0; rx_valid <= 1'b0;
      rx_data <= 8'h00; resp <= 8'h00; cap_size <= '0; cap_stat <= 1'b0; cap_open <= 1'b0;
    end else begin
      cs_q <= cs_assert;
      if (cs_assert && !cs_q) begin
        sess <= sess + 1;
        slot <= 0;
        if (eng_busy) early_cs <= early_cs + 1;
      end
      if (boot_cnt != 0) boot_cnt <= boot_cnt - 1;
      if (tail_cnt != 0) tail_cnt <= tail_cnt - 1;
      if (tx_valid && tx_ready) begin
        if (eng_busy) viol <= viol + 1;
        if (log_n < 16) begin
          log_data[log_n] <= tx_data;
          log_quad[log_n] <= tx_quad;
          log_sess[log_n] <= sess;
        end
        log_n     <= log_n + 1;
        in_flight <= 1'b1;
        tx_ready  <= 1'b0;
        lat_cnt   <= $urandom % 5;
        if (sess == 2 && slot == 5)      resp <= die_v;
        else if (sess == 2 && slot == 6) resp <= eid_v;
        else                             resp <= 8'($urandom);
        if (cs_assert && !cs_q) slot <= 1; else slot <= slot + 1;
      end else if (!in_flight) begin
        tx_ready <= ($urandom % 3) != 0;
      end
      if (in_flight && !rx_valid) begin
        if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
        else begin
          rx_valid <= 1'b1;
          rx_data  <= resp;
        end
      end
      if (rx_valid && rx_ready) begin
        rx_valid  <= 1'b0;
        in_flight <= 1'b0;
        rx_acc    <= rx_acc + 1;
        tail_cnt  <= $urandom % 4;
      end
      if (done) begin
        done_n   <= done_n + 1;
        cap_size <= det_size;
        cap_stat <= status;
        cap_open <= cs_assert | xfer_en;
      end
    end
  end

  function automatic logic [SZW-1:0] ref_size(input logic [7:0] d, input logic [7:0] e);
    if (d != 8'h5D) return '0;
    if (e == 8'h26 || e[7:5] == 3'd2) return SZW'(8 * MIB);
    if (e[7:5] == 3'd0) return SZW'(2 * MIB);
    if (e[7:5] == 3'd1) return SZW'(4 * MIB);
    return SZW'(MIB);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [7:0] d, input logic [7:0] e, input int boot);
    logic [SZW-1:0] es;
    logic           est;
    bit             seq_ok;
    int             waited;
    rst_n  = 1'b0;
    die_v  = d;
    eid_v  = e;
    boot_v = boot;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!xfer_en && !cs_assert && !tx_valid && !rx_ready && !done &&
          det_size == '0 && !status, "R1", "reset outputs",
          {xfer_en, cs_assert, tx_valid, rx_ready, done, status}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cs_assert && !tx_valid && !done, "R1", "first cycle after reset",
          {cs_assert, tx_valid, done}, 0);
    waited = 0;
    while (done_n == 0 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    check(done_n != 0, "R10", "watchdog: done never seen", waited, 0);
    repeat (25) @(negedge clk);
    es  = ref_size(d, e);
    est = (es != SZW'(WANT));
    check(done_n == 1, "R10", "done pulse count", done_n, 1);
    check(!cap_open, "R10", "port open during done", cap_open, 0);
    check(det_size == cap_size && status == cap_stat, "R10", "result not held",
          det_size, cap_size);
    check(log_n == 8, "R10", "bytes after done / total bytes", log_n, 8);
    check(cap_size == es, (d == 8'h5D) ? "R8" : "R7", "size (R6 filler ignored)",
          cap_size, es);
    check(cap_stat == est, "R9", "status", cap_stat, est);
    check(log_n >= 1 && log_data[0] == 8'hF5 && log_quad[0] && log_sess[0] == 1,
          "R2", "reset-enable byte", log_data[0], 8'hF5);
    seq_ok = (sess == 2) && (log_n == 8);
    for (int k = 1; k < 8; k++) begin
      if (k < log_n) begin
        if (log_data[k] != ((k == 1) ? 8'h9F : 8'hFF) || log_quad[k] || log_sess[k] != 2)
          seq_ok = 1'b0;
      end
    end
    check(seq_ok, "R3", "ID window script / chip-select sessions", sess, 2);
    check(rx_acc == log_n, "R4", "responses taken per byte", rx_acc, log_n);
    check(viol == 0 && early_cs == 0, "R5", "activity while engine busy",
          viol + early_cs, 0);
  endtask

  initial begin
    int unused_seed;
    die_v = 8'h00; eid_v = 8'h00; boot_v = 0;
    unused_seed = $urandom(32'h51ED);
    run_case(8'h5D, 8'h26, 0);
    run_case(8'h5D, 8'h40, 3);
    run_case(8'h5D, 8'h5F, 1);
    run_case(8'h5D, 8'h00, 6);
    run_case(8'h5D, 8'h3F, 2);
    run_case(8'h5D, 8'h27, 0);
    run_case(8'h5D, 8'h60, 4);
    run_case(8'h5D, 8'hE0, 5);
    run_case(8'h5C, 8'h26, 0);
    run_case(8'h00, 8'h40, 2);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d, e;
      d = ($urandom % 3 != 0) ? 8'h5D : 8'($urandom);
      e = ($urandom % 4 == 0) ? 8'h26 : 8'($urandom);
      run_case(d, e, $urandom % 8);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL R10 global watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule